// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block sits in front of the data fetch of a hash DMA engine. It turns a request for a transfer into a sequence of address/length segment commands for a downstream reader. In list mode it walks a table of 8-byte descriptors in memory. Each descriptor is two little-endian 32-bit words. The length word sits at byte offset 0 and the address word at byte offset 4. Bit 31 of the length word marks the final entry. The walker fetches both words of one descriptor through a 32-bit read port, hands the masked segment downstream, and waits for it to be taken before it fetches the next descriptor. In direct mode no memory is read: one segment is built from the source address and source length inputs.

A walk ends in one of three ways. After the final segment is accepted, `done` pulses. If the entry limit is used up without a final flag, `fail_limit` pulses. If a read response carries an error, `fail_bus` pulses. All three interfaces (read request, read response, segment) are valid/ready. A valid with its payload is held until the matching ready is seen at a clock edge. The walker accepts read responses only while it is waiting for one. A stalled downstream reader stalls the walk without losing anything.

Top module: `sg_walker`

## Requirements
- R1: After reset `busy`, `rd_req_valid`, `seg_valid`, `done`, `fail_limit` and `fail_bus` are low, and no request or segment is presented while `busy` is low.
- R2: In list mode descriptor i is fetched with two reads. The length word is read first at base + 8*i, then the address word at base + 8*i + 4. The base is `{base_hi, base_lo}` when HI_EN is 1, and `base_lo` zero-extended when HI_EN is 0.
- R3: A segment carries length word bits [27:0] as `seg_len` and address word bits [30:0] as `seg_addr`. All other bits of both words (bits 30:28 of the length word and bit 31 of the address word) have no effect on the segment.
- R4: A length word with bit 31 set ends the walk once that descriptor's segment is accepted. `done` is high for exactly one cycle, on the cycle after the accepting edge.
- R5: Only one descriptor is in flight. No read request is presented while a segment is pending, and the next length read follows acceptance of the previous segment.
- R6: If MAX_DESC segments are accepted and none of them had the final flag, `fail_limit` pulses for one cycle after the last acceptance. No `done` follows and no further read is issued.
- R7: A read response with `rd_rsp_err` high aborts the walk. `fail_bus` pulses on the next cycle, and no segment is issued for the descriptor being fetched.
- R8: In direct mode (`sg_mode` low at start) exactly one segment is issued, with `base_lo[30:0]` and `src_len[27:0]`. No memory read is issued, and `done` follows its acceptance.
- R9: `rd_req_valid` and `seg_valid` stay high with unchanged payload until accepted.
- R10: `start` is sampled only while idle, and it captures the mode, base and length at that edge. A `start` during a walk is ignored: it does not alter the walk and does not queue a second one.
- R11: `busy` rises on the cycle after an accepted `start` and falls in the same cycle that one of `done`, `fail_limit` or `fail_bus` pulses. At most one of these pulses at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| sg_mode | input | 1 | 1 = descriptor list, 0 = direct segment |
| base_lo | input | 32 | List base low word, or source address in direct mode |
| base_hi | input | 32 | List base high word (used when HI_EN = 1) |
| src_len | input | 32 | Source length for direct mode |
| busy | output | 1 | Walk in progress |
| rd_req_valid | output | 1 | Descriptor word read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | MEM_AW | Byte address of the descriptor word |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Walker waits for a response |
| rd_rsp_data | input | 32 | Read data word |
| rd_rsp_err | input | 1 | Read response error |
| seg_valid | output | 1 | Segment command valid |
| seg_ready | input | 1 | Segment command accepted |
| seg_addr | output | SEG_AW | Segment byte address |
| seg_len | output | SEG_LW | Segment byte length |
| done | output | 1 | One-cycle pulse: walk completed |
| fail_limit | output | 1 | One-cycle pulse: entry limit reached without final flag |
| fail_bus | output | 1 | One-cycle pulse: read error aborted the walk |

## Verification
A start accepted at one edge shows `busy` and the first request (a read in list mode, a segment in direct mode) from the next cycle. A read accepted at an edge is followed by a response at the bench's chosen delay, and the walker presents the next request one cycle after that response is taken. The end pulses appear exactly one cycle after the accepting segment edge or the erroring response edge. The bench waits for the pulse on falling edges, checks `busy` in that same sample, and checks one sample later that the pulse has cleared. Handshakes, read addresses and payload holds are observed at the rising edge where they take effect. Segment lists and read counts are compared after the walk against a model of the descriptor table.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W        = 32;
  localparam int DESC_BYTES    = 8;
  localparam int LAST_FLAG_BIT = 31;

  typedef enum logic [2:0] {
    W_IDLE,
    W_LEN_REQ,
    W_LEN_RSP,
    W_ADR_REQ,
    W_ADR_RSP,
    W_SEG
  } walk_state_t;
endpackage

// File: rtl/sgw_desc_addr.sv
module sgw_desc_addr #(
  parameter int MEM_AW = 64,
  parameter int IDX_W  = 4,
  parameter bit HI_EN  = 1'b1
) (
  input  logic [31:0]       base_lo,
  input  logic [31:0]       base_hi,
  input  logic [IDX_W-1:0]  idx,
  input  logic              word_sel,
  output logic [MEM_AW-1:0] addr
);
  logic [63:0] base_full;

  generate
    if (HI_EN) begin : g_wide
      assign base_full = {base_hi, base_lo};
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^base_hi;
      assign base_full = {32'd0, base_lo};
    end
  endgenerate

  // byte offset = 8*idx + 4*word_sel
  logic [MEM_AW-1:0] offset;
  assign offset = MEM_AW'({idx, word_sel, 2'b00});
  assign addr   = base_full[MEM_AW-1:0] + offset;
endmodule

// File: rtl/sgw_field_mask.sv
module sgw_field_mask #(
  parameter int SEG_AW   = 31,
  parameter int SEG_LW   = 28,
  parameter int LAST_BIT = 31
) (
  input  logic [31:0]       len_word,
  input  logic [31:0]       addr_word,
  output logic [SEG_AW-1:0] seg_addr,
  output logic [SEG_LW-1:0] seg_len,
  output logic              last
);
  assign seg_len  = len_word[SEG_LW-1:0];
  assign seg_addr = addr_word[SEG_AW-1:0];
  assign last     = len_word[LAST_BIT];

  logic unused_bits;
  assign unused_bits = ^{len_word[LAST_BIT-1:SEG_LW], addr_word[31:SEG_AW]};
endmodule

// File: rtl/sg_walker.sv
module sg_walker #(
  parameter int MAX_DESC = 16,
  parameter int MEM_AW   = 64,
  parameter int SEG_AW   = 31,
  parameter int SEG_LW   = 28,
  parameter bit HI_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sg_mode,
  input  logic [31:0]       base_lo,
  input  logic [31:0]       base_hi,
  input  logic [31:0]       src_len,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [MEM_AW-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [31:0]       rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [SEG_AW-1:0] seg_addr,
  output logic [SEG_LW-1:0] seg_len,
  output logic              done,
  output logic              fail_limit,
  output logic              fail_bus
);
  import sgw_pkg::*;

  localparam int IDX_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_DESC - 1);

  walk_state_t      state;
  logic [IDX_W-1:0] idx;
  logic [31:0]      r_base_lo, r_base_hi;
  logic [31:0]      r_len_word, r_addr_word;
  logic             r_sg;
  logic             desc_last;

  sgw_desc_addr #(.MEM_AW(MEM_AW), .IDX_W(IDX_W), .HI_EN(HI_EN)) u_addr (
    .base_lo  (r_base_lo),
    .base_hi  (r_base_hi),
    .idx      (idx),
    .word_sel (state == W_ADR_REQ),
    .addr     (rd_req_addr)
  );

  sgw_field_mask #(.SEG_AW(SEG_AW), .SEG_LW(SEG_LW), .LAST_BIT(LAST_FLAG_BIT)) u_mask (
    .len_word  (r_len_word),
    .addr_word (r_addr_word),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .last      (desc_last)
  );

  assign busy         = (state != W_IDLE);
  assign rd_req_valid = (state == W_LEN_REQ) || (state == W_ADR_REQ);
  assign rd_rsp_ready = (state == W_LEN_RSP) || (state == W_ADR_RSP);
  assign seg_valid    = (state == W_SEG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= W_IDLE;
      idx         <= '0;
      r_base_lo   <= '0;
      r_base_hi   <= '0;
      r_len_word  <= '0;
      r_addr_word <= '0;
      r_sg        <= 1'b0;
      done        <= 1'b0;
      fail_limit  <= 1'b0;
      fail_bus    <= 1'b0;
    end else begin
      done       <= 1'b0;
      fail_limit <= 1'b0;
      fail_bus   <= 1'b0;
      unique case (state)
        W_IDLE: begin
          if (start) begin
            r_base_lo <= base_lo;
            r_base_hi <= base_hi;
            r_sg      <= sg_mode;
            idx       <= '0;
            if (sg_mode) begin
              state <= W_LEN_REQ;
            end else begin
              r_len_word  <= src_len;
              r_addr_word <= base_lo;
              state       <= W_SEG;
            end
          end
        end
        W_LEN_REQ: if (rd_req_ready) state <= W_LEN_RSP;
        W_LEN_RSP: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_err) begin
              fail_bus <= 1'b1;
              state    <= W_IDLE;
            end else begin
              r_len_word <= rd_rsp_data;
              state      <= W_ADR_REQ;
            end
          end
        end
        W_ADR_REQ: if (rd_req_ready) state <= W_ADR_RSP;
        W_ADR_RSP: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_err) begin
              fail_bus <= 1'b1;
              state    <= W_IDLE;
            end else begin
              r_addr_word <= rd_rsp_data;
              state       <= W_SEG;
            end
          end
        end
        W_SEG: begin
          if (seg_ready) begin
            if (!r_sg || desc_last) begin
              done  <= 1'b1;
              state <= W_IDLE;
            end else if (idx == IDX_LAST) begin
              fail_limit <= 1'b1;
              state      <= W_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= W_LEN_REQ;
            end
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
  parameter int MEM_AW = 64,
  parameter int SEG_AW = 31,
  parameter int SEG_LW = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [MEM_AW-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              rd_rsp_ready,
  input logic              rd_rsp_err,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [SEG_AW-1:0] seg_addr,
  input logic [SEG_LW-1:0] seg_len,
  input logic              done,
  input logic              fail_limit,
  input logic              fail_bus
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!seg_valid && !rd_req_valid && !rd_rsp_ready));

  assert_done_after_seg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(seg_valid && seg_ready));

  assert_one_inflight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (!rd_req_valid && !rd_rsp_ready));

  assert_limit_after_seg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_limit |-> $past(seg_valid && seg_ready));

  assert_bus_after_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_bus |-> $past(rd_rsp_valid && rd_rsp_ready && rd_rsp_err));

  assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  assert_single_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail_limit, fail_bus}));

  assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail_limit || fail_bus) |-> !busy);
endmodule

bind sg_walker sgw_checker #(.MEM_AW(MEM_AW), .SEG_AW(SEG_AW), .SEG_LW(SEG_LW)) u_chk (.*);

// File: tb/tb_sg_walker.sv
`timescale 1ns/1ps
module tb_sg_walker;
  localparam int MAXD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sg_mode = 1'b0;
  logic [31:0] base_lo = '0, base_hi = '0, src_len = '0;
  logic        busy, rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready, rd_rsp_err;
  logic [63:0] rd_req_addr;
  logic [31:0] rd_rsp_data;
  logic        seg_valid, seg_ready, done, fail_limit, fail_bus;
  logic [30:0] seg_addr;
  logic [27:0] seg_len;

  always #2.5 clk = ~clk;

  sg_walker #(.MAX_DESC(MAXD), .MEM_AW(64), .SEG_AW(31), .SEG_LW(28), .HI_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sg_mode(sg_mode), .base_lo(base_lo),
    .base_hi(base_hi), .src_len(src_len), .busy(busy), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .done(done), .fail_limit(fail_limit), .fail_bus(fail_bus));

  int nchk = 0, nerr = 0;
  bit finished = 0;
  logic [31:0] d_len [MAXD];
  logic [31:0] d_adr [MAXD];
  logic [63:0] cur_base;
  int err_read = -1;
  int rd_count = 0;
  int n_seg = 0;
  logic [30:0] got_a [64];
  logic [27:0] got_l [64];
  int hold_viol = 0, overlap_viol = 0, stalls = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory read responder
  logic pend = 0; int wait_c = 0; logic [31:0] pend_data; logic pend_err;
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_req_ready <= 0; rd_rsp_valid <= 0; rd_rsp_data <= '0; rd_rsp_err <= 0;
      pend <= 0; wait_c <= 0;
    end else begin
      if (rd_rsp_valid && rd_rsp_ready) begin
        rd_rsp_valid <= 0; pend <= 0;
      end else if (pend && !rd_rsp_valid) begin
        if (wait_c == 0) begin
          rd_rsp_valid <= 1; rd_rsp_data <= pend_data; rd_rsp_err <= pend_err;
        end else wait_c <= wait_c - 1;
      end
      if (rd_req_valid && rd_req_ready) begin
        // R2: read k goes to base + 4*k (length word first, then address word)
        chk(rd_req_addr === cur_base + 64'(rd_count) * 64'd4, "R2", "read address",
            rd_req_addr, cur_base + 64'(rd_count) * 64'd4);
        if ((rd_count >> 1) < MAXD)
          pend_data <= rd_count[0] ? d_adr[rd_count >> 1] : d_len[rd_count >> 1];
        else pend_data <= '0;
        pend_err <= (rd_count == err_read);
        pend     <= 1;
        wait_c   <= $urandom % 3;
        rd_count++;
      end
      rd_req_ready <= !(pend || (rd_req_valid && rd_req_ready)) && ($urandom % 4 != 0);
    end
  end

  // segment sink
  logic prev_stall = 0; logic [30:0] prev_a; logic [27:0] prev_l;
  always @(posedge clk) begin
    if (!rst_n) begin
      seg_ready <= 0; prev_stall = 0;
    end else begin
      if (prev_stall && (!seg_valid || seg_addr !== prev_a || seg_len !== prev_l)) hold_viol++;
      prev_stall = seg_valid && !seg_ready;
      if (prev_stall) stalls++;
      prev_a = seg_addr; prev_l = seg_len;
      if (seg_valid && rd_req_valid) overlap_viol++;
      if (seg_valid && seg_ready) begin
        if (n_seg < 64) begin got_a[n_seg] = seg_addr; got_l[n_seg] = seg_len; end
        n_seg++;
      end
      seg_ready <= ($urandom % 3 != 0);
    end
  end

  // kind: 0 done, 1 limit, 2 bus error
  task automatic walk(input bit sg, input bit mid_start, input string tag);
    int exp_n, exp_reads, exp_kind, kind, cyc;
    logic [30:0] ea [MAXD];
    logic [27:0] el [MAXD];
    exp_n = 0; exp_reads = 0; exp_kind = 0;
    if (sg) begin
      for (int i = 0; i < MAXD; i++) begin
        if (err_read == 2*i)     begin exp_kind = 2; exp_reads = 2*i + 1; break; end
        if (err_read == 2*i + 1) begin exp_kind = 2; exp_reads = 2*i + 2; break; end
        ea[exp_n] = d_adr[i][30:0]; el[exp_n] = d_len[i][27:0]; exp_n++;
        exp_reads = 2*i + 2;
        if (d_len[i][31]) begin exp_kind = 0; break; end
        if (i == MAXD - 1) exp_kind = 1;
      end
    end else begin
      ea[0] = base_lo[30:0]; el[0] = src_len[27:0]; exp_n = 1;
    end
    cur_base = {base_hi, base_lo};
    rd_count = 0; n_seg = 0;
    @(negedge clk); sg_mode = sg; start = 1;
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R11", {tag, " busy after start"}, busy, 1);
    if (mid_start) begin
      repeat (3) @(negedge clk);
      base_lo = ~base_lo; base_hi = base_hi ^ 32'h55; src_len = ~src_len; sg_mode = ~sg_mode;
      start = 1; @(negedge clk); start = 0;
    end
    kind = -1;
    for (cyc = 0; cyc < 5000; cyc++) begin
      if (done || fail_limit || fail_bus) break;
      @(negedge clk);
    end
    if (done) kind = 0; else if (fail_limit) kind = 1; else if (fail_bus) kind = 2;
    chk(busy === 1'b0, "R11", {tag, " busy low with end pulse"}, busy, 0);
    chk(kind == exp_kind, exp_kind == 0 ? (sg ? "R4" : "R8") : (exp_kind == 1 ? "R6" : "R7"),
        {tag, " end kind"}, 64'(kind), 64'(exp_kind));
    chk(n_seg == exp_n, "R5", {tag, " segment count"}, 64'(n_seg), 64'(exp_n));
    chk(rd_count == exp_reads, sg ? "R6" : "R8", {tag, " read count"}, 64'(rd_count), 64'(exp_reads));
    for (int i = 0; i < exp_n && i < n_seg; i++) begin
      chk(got_a[i] === ea[i], "R3", {tag, " seg addr"}, 64'(got_a[i]), 64'(ea[i]));
      chk(got_l[i] === el[i], "R3", {tag, " seg len"}, 64'(got_l[i]), 64'(el[i]));
    end
    @(negedge clk);
    chk({done, fail_limit, fail_bus} === 3'b000, "R4", {tag, " pulse one cycle"},
        64'({done, fail_limit, fail_bus}), 0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R10", {tag, " no queued walk"}, busy, 0);
    err_read = -1;
  endtask

  task automatic fill(input int last_at);
    for (int i = 0; i < MAXD; i++) begin
      d_len[i] = $urandom; d_adr[i] = $urandom;
      d_len[i][31] = (i == last_at);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    chk(busy === 0 && rd_req_valid === 0 && seg_valid === 0, "R1", "idle in reset",
        {busy, rd_req_valid, seg_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({busy, rd_req_valid, seg_valid, done, fail_limit, fail_bus} === 6'b0, "R1",
        "idle after reset", {busy, rd_req_valid, seg_valid, done, fail_limit, fail_bus}, 0);

    // direct mode, upper bits set in both fields (R8, R3)
    for (int k = 0; k < 3; k++) begin
      base_lo = $urandom | 32'h8000_0000; src_len = $urandom | 32'hF000_0000;
      walk(1'b0, 1'b0, "direct");
    end
    // single descriptor with final flag
    base_lo = $urandom; base_hi = $urandom; fill(0);
    walk(1'b1, 1'b0, "single");
    // final flag at the last allowed slot
    base_lo = $urandom; base_hi = 32'h3; fill(MAXD - 1);
    walk(1'b1, 1'b0, "last slot");
    // no final flag: limit (R6)
    base_lo = $urandom; base_hi = $urandom; fill(-1);
    walk(1'b1, 1'b0, "limit");
    // read errors (R7): on a length word and on an address word
    fill(5); err_read = 4; walk(1'b1, 1'b0, "err len");
    fill(5); err_read = 1; walk(1'b1, 1'b0, "err adr");
    // start during a walk is ignored (R10)
    base_lo = $urandom; base_hi = $urandom; fill(3);
    walk(1'b1, 1'b1, "mid start");
    // random walks
    for (int k = 0; k < 10; k++) begin
      base_lo = $urandom; base_hi = $urandom; fill($urandom % MAXD);
      walk(1'b1, 1'b0, "random");
    end
    chk(stalls > 0, "R9", "segment stalls seen", 64'(stalls), 1);
    chk(hold_viol == 0, "R9", "payload held during stall", 64'(hold_viol), 0);
    chk(overlap_viol == 0, "R5", "no read while segment pending", 64'(overlap_viol), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
    end
    $finish;
  end
endmodule